// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Byte Read

This block is a 16-bit up-counter that runs freely and is read through a byte-wide register port. Its count enable comes from one of two sources. The first is a power-of-two divider on the bus clock, with divisors from 1 to 64. The second is an external clock pin, which is synchronized to the bus clock and counts on its rising edges. A 3-bit select field in a control register picks the source. A write-only bit in the same register clears both the counter and the divider.

Software reads the count one byte at a time. To keep the two halves consistent, a read of the high byte takes a snapshot of the low byte at that moment. Later low-byte reads return this snapshot until one low-byte read releases it. High-byte reads made while a snapshot is pending do not replace it. A high read with no matching low read, for example one made while debugging, therefore leaves the old snapshot waiting for the next low read.

Top module: `tmr_coherent_counter`

## Requirements
- R1: With select codes 0 to 6, the counter advances once every 2^code bus clock cycles. After a clear, k bus edges leave the count at floor(k / 2^code).
- R2: With select code 7, the counter advances once for each rising edge of `ext_clk` after a two-flop synchronizer. Holding the pin at a steady level adds nothing.
- R3: Synchronous reset sets the select field to 0, the counter to 0 and `bus_rdata` to 0, and leaves no snapshot pending. On the first edge after reset the count goes from 0 to 1.
- R4: Address 0 is the control register. Write bits [2:0] set the select code, and write bit 4 requests a counter clear. A read returns the select code in bits [2:0] and zero in every other bit, so bit 4 always reads as 0.
- R5: A control write with bit 4 set clears the counter and the divider on the same edge. Counting then restarts with a full prescaler period.
- R6: A read of address 1 returns count[15:8]. If no snapshot is pending, the same read captures count[7:0] into the snapshot.
- R7: While a snapshot is pending, further reads of address 1 leave it unchanged. A read of address 2 returns the snapshot and releases it.
- R8: A read of address 2 with no snapshot pending returns the live count[7:0].
- R9: Writes to addresses 1 and 2 do not change the count or the control register.
- R10: The counter wraps from 0xFFFF to 0x0000.
- R11: Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 count high, 2 count low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_clk | input | 1 | External count clock, asynchronous |

## Verification
Two functions can act on the same edge: a count increment and a high-byte read that captures the low byte. With select code 0 the counter moves on every edge, so every high read in the bench coincides with an increment. The snapshot must hold the value from before that edge. The bench checks this by comparing the 16-bit value assembled from the two byte reads with the number of edges counted since the last clear. The held-snapshot case is tested by leaving hundreds of cycles between the two reads. The low byte must then still match the earlier value, and a second low read must return the live count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;

  localparam int CLR_BIT = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_clk,
  output logic             tick
);
  localparam int N_CODES = 1 << SEL_W;
  localparam int EXT_CODE = N_CODES - 1;
  localparam int DIV_W = EXT_CODE - 1;

  logic [DIV_W-1:0]   div_q;
  logic [2:0]         sync_q;
  logic               ext_rise;
  logic [N_CODES-1:0] taps;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], ext_clk};
  end
  assign ext_rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  genvar k;
  generate
    for (k = 0; k < N_CODES; k++) begin : g_tap
      if (k == 0) begin : g_bypass
        assign taps[k] = 1'b1;
      end else if (k == EXT_CODE) begin : g_ext
        assign taps[k] = ext_rise;
      end else begin : g_div
        assign taps[k] = &div_q[k-1:0];
      end
    end
  endgenerate

  assign tick = taps[sel];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/tmr_regport.sv
module tmr_regport
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [2*DATA_W-1:0] count,
  output logic [SEL_W-1:0]    cfg_sel,
  output logic                cnt_clr,
  output logic                lo_latched,
  output logic [DATA_W-1:0]   lo_hold,
  output logic [DATA_W-1:0]   bus_rdata
);
  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << SEL_W) - 1) | DATA_W'(1 << CLR_BIT);

  logic       acc_rd, acc_wr;
  reg_addr_e  addr;
  logic       wdata_unused;

  assign addr         = reg_addr_e'(bus_addr);
  assign acc_rd       = bus_sel & ~bus_wr;
  assign acc_wr       = bus_sel & bus_wr;
  assign cnt_clr      = acc_wr && (addr == REG_CTRL) && bus_wdata[CLR_BIT];
  assign wdata_unused = ^(bus_wdata & ~USED_MASK);

  always_ff @(posedge clk) begin
    if (rst) cfg_sel <= '0;
    else if (acc_wr && addr == REG_CTRL) cfg_sel <= bus_wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_latched <= 1'b0;
      lo_hold    <= '0;
    end else if (acc_rd) begin
      if (addr == REG_CNT_HI && !lo_latched) begin
        lo_latched <= 1'b1;
        lo_hold    <= count[DATA_W-1:0];
      end else if (addr == REG_CNT_LO) begin
        lo_latched <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (acc_rd) begin
      case (addr)
        REG_CTRL:   bus_rdata <= DATA_W'(cfg_sel);
        REG_CNT_HI: bus_rdata <= count[2*DATA_W-1:DATA_W];
        REG_CNT_LO: bus_rdata <= lo_latched ? lo_hold : count[DATA_W-1:0];
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_coherent_counter.sv
module tmr_coherent_counter #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk
);
  localparam int CNT_W = 2 * DATA_W;

  logic [SEL_W-1:0]  cfg_sel;
  logic              cnt_clr;
  logic              cnt_en;
  logic [CNT_W-1:0]  count_q;
  logic              lo_latched;
  logic [DATA_W-1:0] lo_hold;

  tmr_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst(rst), .clr(cnt_clr), .sel(cfg_sel),
    .ext_clk(ext_clk), .tick(cnt_en)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_en), .count(count_q)
  );

  tmr_regport #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count_q),
    .cfg_sel(cfg_sel), .cnt_clr(cnt_clr), .lo_latched(lo_latched),
    .lo_hold(lo_hold), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/tmr_counter_chk.sv
module tmr_counter_chk #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [1:0]          bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [SEL_W-1:0]    cfg_sel,
  input logic                cnt_en,
  input logic [2*DATA_W-1:0] count_q,
  input logic                lo_latched,
  input logic [DATA_W-1:0]   lo_hold
);
  localparam logic [SEL_W-1:0] EXT_CODE = '1;

  logic rd, clr_req, lo_rd;
  assign rd      = bus_sel && !bus_wr;
  assign lo_rd   = rd && bus_addr == 2'd2;
  assign clr_req = bus_sel && bus_wr && bus_addr == 2'd0 && bus_wdata[tmr_pkg::CLR_BIT];

  // R3: reset leaves a clean state
  p_reset_state_r3: assert property (@(posedge clk)
    rst |=> (count_q == '0 && bus_rdata == '0 && !lo_latched && cfg_sel == '0));

  // R5: clear request zeroes the counter on the following cycle
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> count_q == '0);

  // R2: an external edge yields a single-cycle enable
  p_ext_single_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel == EXT_CODE && cnt_en && !(bus_sel && bus_wr)) |=> !cnt_en);

  // R7: a pending snapshot is frozen until a low-byte read
  p_hold_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (lo_latched && !lo_rd) |=> (lo_latched && $stable(lo_hold)));

  // R7: a low-byte read releases the snapshot
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    lo_rd |=> !lo_latched);

  // R4: control readback has zero above the select field
  p_ctrl_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == 2'd0) |=> (bus_rdata >> SEL_W) == '0);

  // R10: wrap to zero
  p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (count_q == '1 && cnt_en && !clr_req) |=> count_q == '0);

  // R11: read data holds without a read
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));
endmodule

bind tmr_coherent_counter tmr_counter_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cfg_sel(cfg_sel), .cnt_en(cnt_en), .count_q(count_q),
  .lo_latched(lo_latched), .lo_hold(lo_hold)
);

// File: tb/tb_tmr_coherent_counter.sv
`timescale 1ns/100ps
module tb_tmr_coherent_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_clk = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_coherent_counter dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk)
  );

  // {code[2:0], idle edges after clear[7:0], expected count[15:0]}
  localparam int NV = 9;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 8'd5,   16'd5},
    {3'd1, 8'd7,   16'd3},
    {3'd2, 8'd9,   16'd2},
    {3'd3, 8'd40,  16'd5},
    {3'd4, 8'd100, 16'd6},
    {3'd5, 8'd70,  16'd2},
    {3'd6, 8'd200, 16'd3},
    {3'd6, 8'd63,  16'd0},
    {3'd6, 8'd64,  16'd1}
  };

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic read_pair(output logic [15:0] v);
    logic [7:0] h, l;
    bus_read(2'd1, h);
    bus_read(2'd2, l);
    v = {h, l};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0]  b, b2, b3;
    logic [15:0] v;
    @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R3 rdata in reset", {8'h0, bus_rdata}, 16'h0000);
    rst = 1'b0;
    bus_read(2'd0, b);
    chk("R3 select after reset", {8'h0, b}, 16'h0000);
    read_pair(v);
    chk("R3 count from zero", v, 16'd1);

    // R1 and R5: divider table, each entry starts from a clear
    for (int i = 0; i < NV; i++) begin
      bus_write(2'd0, 8'h10 | {5'd0, VEC[i][26:24]});
      repeat (int'(VEC[i][23:16])) @(negedge clk);
      read_pair(v);
      chk($sformatf("R1 R5 code %0d", VEC[i][26:24]), v, VEC[i][15:0]);
    end

    // R4: clear bit reads as zero
    bus_write(2'd0, 8'h15);
    bus_read(2'd0, b);
    chk("R4 ctrl readback", {8'h0, b}, 16'h0005);

    // R9: writes to counter bytes are ignored
    bus_write(2'd0, 8'h10);
    bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'hFF);
    read_pair(v);
    chk("R9 count after writes", v, 16'd2);
    bus_read(2'd0, b);
    chk("R9 ctrl after writes", {8'h0, b}, 16'h0000);

    // R6 R7 R8: snapshot held across a second high read
    bus_write(2'd0, 8'h10);
    repeat (10) @(negedge clk);
    bus_read(2'd1, b);
    chk("R6 first high", {8'h0, b}, 16'h0000);
    repeat (300) @(negedge clk);
    bus_read(2'd1, b);
    chk("R6 second high", {8'h0, b}, 16'h0001);
    bus_read(2'd2, b2);
    chk("R7 held low", {8'h0, b2}, 16'h000A);
    bus_read(2'd2, b3);
    chk("R8 live low", {8'h0, b3}, 16'h0039);

    // R11: read data holds, address 3 reads zero
    repeat (5) @(negedge clk);
    chk("R11 rdata holds", {8'h0, bus_rdata}, 16'h0039);
    bus_read(2'd3, b);
    chk("R11 addr 3", {8'h0, b}, 16'h0000);

    // R2: external clock, edges not levels
    bus_write(2'd0, 8'h17);
    for (int p = 0; p < 5; p++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    read_pair(v);
    chk("R2 five edges", v, 16'd5);
    ext_clk = 1'b1;
    repeat (40) @(negedge clk);
    read_pair(v);
    chk("R2 rising edge", v, 16'd6);
    repeat (40) @(negedge clk);
    read_pair(v);
    chk("R2 steady level", v, 16'd6);
    ext_clk = 1'b0;

    // R10: wrap, with the high read coinciding with the increment
    bus_write(2'd0, 8'h10);
    repeat (65534) @(negedge clk);
    read_pair(v);
    chk("R10 before wrap", v, 16'hFFFE);
    read_pair(v);
    chk("R10 after wrap", v, 16'h0000);

    summary();
  end
endmodule